// File: doc/BRIEF.md
# Parallel Instruction Boundary Finder

This block sits between instruction fetch and a bank of four full decoders. Each cycle it receives a 16-byte window whose byte 0 lies at the current program counter, together with a per-byte valid mask. Every byte position has its own length pre-decoder, because any byte could begin an instruction. Those lengths are chained from byte 0 to mark up to four real instruction starts. The block reports each start and its length, and it tells fetch how many bytes to shift the window by.

The pre-decoders differ by position. The one at byte 0 is complete: it understands prefix chains and every length. The ones at higher positions are trimmed. They reject any prefix byte and any instruction that would run past the end of the window, and they raise an "unhandled" flag in those cases. When the chain reaches a flagged position it stops there, and the shift amount ends at that position. On the following cycle the rejected instruction sits at byte 0, where the complete decoder handles it.

The encoding uses lengths of 1 to 11 bytes. Bits [7:6] of an opcode byte select 1, 2, 4 or 8 bytes, and bytes 0xF0 to 0xF7 act as one-byte prefixes. Selection is combinational. The chain is a walk whose stop reason is one of four named states: FULL (four slots issued), DEFER (stopped at an unhandled position), EDGE (stopped at the window end or at an instruction whose bytes have not all arrived), and STARVE (byte 0 itself cannot complete). The walk starts at position 0 and moves from one slot to the next by adding the issued length. Each slot step ends in one of three ways: it issues and advances, it halts in DEFER, or it halts in EDGE. STARVE is possible only at the first step, and FULL is reached after the fourth issue. The shift amount and the need-more-bytes output are produced from the stop state.

Top module: `vlb_boundary_finder`

## Requirements
- R1: A byte outside 0xF0..0xF7 is an opcode whose bits [7:6] give the length: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R2: At byte 0, up to three leading bytes in 0xF0..0xF7 are prefixes and each adds one to the length. After three prefixes, the next byte is taken as the opcode even if it lies in 0xF0..0xF7, in which case its length is 8.
- R3: Slot 0 starts at byte 0. Each further slot starts at the previous slot's start plus its length. Slots fill from slot 0 upward with no gaps, at most four are issued, and the walk stops when the next start reaches byte 16.
- R4: A byte in 0xF0..0xF7 at a start position other than 0 is not issued. The walk stops before it, so the advance equals that position.
- R5: At a start position k other than 0, an instruction whose length exceeds 16−k, or whose end lies beyond the valid bytes, is not issued, and the walk stops before it.
- R6: The valid byte count is the run of ones at the low end of the valid mask (bit i covers byte i). Mask bits above the first zero are ignored.
- R7: When the instruction at byte 0 does not fit within the valid bytes, no slot is issued, the advance is zero and need_bytes is high.
- R8: While dn_ready is high, the advance equals the sum of the issued lengths. While dn_ready is low, the advance is zero and the slots are still reported.
- R9: After an accepted cycle that stopped at an unhandled position whose whole instruction lay within the valid bytes, the next window issues that instruction as slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| win_bytes | input | 128 | Fetch window, byte i in bits [8i+7:8i], byte 0 at the program counter |
| win_valid | input | 16 | Per-byte valid mask, bit i for byte i |
| dn_ready | input | 1 | Downstream decoders accept this cycle's slots |
| slot_vld | output | 4 | Slot i carries an instruction |
| slot_ofs | output | 16 | Start byte of slot i in bits [4i+3:4i] |
| slot_len | output | 16 | Length of slot i in bits [4i+3:4i] |
| adv_bytes | output | 5 | Bytes to shift the window by, 0 to 16 |
| need_bytes | output | 1 | Byte 0 instruction is not yet complete |

## Verification
The bench aims at the places where the chain must halt. These are a prefix at a trimmed position, an instruction that spills over the window end or past the valid bytes, and a mask with ones above a zero. A design that mishandled any of them would issue a slot over bytes it cannot size, or would shift the window past an instruction that then never decodes. A prefix chain of exactly three followed by a fourth prefix-range byte tests the cap on prefix counting. A wrong cap gives a length of 12 or miscounts the opcode. A random stream with random readiness confirms that every deferral issues on the next accepted window, so a halt that failed to make progress would appear as a missing slot 0.

// File: rtl/vlb_pkg.sv
package vlb_pkg;

    typedef enum logic [1:0] {
        STOP_FULL,
        STOP_DEFER,
        STOP_EDGE,
        STOP_STARVE
    } stop_e;

    // Full-byte compare so every bit of the byte participates.
    function automatic logic is_prefix(input logic [7:0] b);
        return (b >= 8'hF0) && (b <= 8'hF7);
    endfunction

    function automatic logic [3:0] base_len(input logic [7:0] b);
        logic [3:0] r;
        unique case (b[7:6])
            2'b00:   r = 4'd1;
            2'b01:   r = 4'd2;
            2'b10:   r = 4'd4;
            default: r = 4'd8;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vlb_lane_len.sv
module vlb_lane_len
    import vlb_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int LANE      = 0,
    parameter int MAX_PFX   = 3,
    parameter int LEN_W     = 4,
    parameter int POS_W     = 5,
    parameter int SPAN      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPAN*8-1:0] lane_bytes,
    input  logic [POS_W-1:0] nvalid,
    output logic [LEN_W-1:0] len,
    output logic             unhandled,
    output logic             incomplete
);
    localparam int EW = POS_W + 1;

    logic [EW-1:0] end_pos;

    generate
        if (LANE == 0) begin : g_full
            logic [LEN_W-1:0] npfx;
            logic             run;
            logic [7:0]       op;
            always_comb begin
                npfx = '0;
                run  = 1'b1;
                for (int i = 0; i < MAX_PFX; i++) begin
                    if (run && is_prefix(lane_bytes[i*8 +: 8])) npfx = npfx + 1'b1;
                    else                                         run  = 1'b0;
                end
                op        = lane_bytes[int'(npfx)*8 +: 8];
                len       = npfx + LEN_W'(base_len(op));
                unhandled = 1'b0;
            end
        end else begin : g_trim
            logic [7:0] op;
            logic [3:0] blen;
            always_comb begin
                op        = lane_bytes[7:0];
                blen      = base_len(op);
                len       = LEN_W'(blen);
                unhandled = is_prefix(op) || ((LANE + int'(blen)) > WIN_BYTES);
            end
            // An accepted trimmed length never reaches beyond the window (R5).
            assert_trim_reach_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !unhandled |-> (LANE + int'(len)) <= WIN_BYTES);
        end
    endgenerate

    always_comb begin
        end_pos    = EW'(LANE) + EW'(len);
        incomplete = end_pos > {1'b0, nvalid};
    end

endmodule

// File: rtl/vlb_chain_select.sv
module vlb_chain_select
    import vlb_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int SLOTS     = 4,
    parameter int LEN_W     = 4,
    parameter int POS_W     = 5,
    parameter int OFS_W     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [WIN_BYTES-1:0][LEN_W-1:0]   lane_len,
    input  logic [WIN_BYTES-1:0]              lane_unh,
    input  logic [WIN_BYTES-1:0]              lane_inc,
    output logic [SLOTS-1:0]                  sel_vld,
    output logic [SLOTS-1:0][OFS_W-1:0]       sel_ofs,
    output logic [SLOTS-1:0][LEN_W-1:0]       sel_len,
    output logic [POS_W-1:0]                  sel_end,
    output stop_e                             stop_now
);
    logic [POS_W-1:0] pos;
    logic [OFS_W-1:0] idx;
    logic             halted;

    // Walk: each step issues, or halts in DEFER / EDGE / STARVE.
    always_comb begin
        pos      = '0;
        idx      = '0;
        halted   = 1'b0;
        stop_now = STOP_FULL;
        sel_vld  = '0;
        sel_ofs  = '0;
        sel_len  = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!halted) begin
                if (pos >= POS_W'(WIN_BYTES)) begin
                    stop_now = STOP_EDGE;
                    halted   = 1'b1;
                end else begin
                    idx = pos[OFS_W-1:0];
                    if (lane_unh[idx]) begin
                        stop_now = STOP_DEFER;
                        halted   = 1'b1;
                    end else if (lane_inc[idx]) begin
                        stop_now = (s == 0) ? STOP_STARVE : STOP_EDGE;
                        halted   = 1'b1;
                    end else begin
                        sel_vld[s] = 1'b1;
                        sel_ofs[s] = idx;
                        sel_len[s] = lane_len[idx];
                        pos        = pos + POS_W'(lane_len[idx]);
                    end
                end
            end
        end
        sel_end = pos;
    end

    generate
        for (genvar s = 1; s < SLOTS; s++) begin : g_chk
            assert_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
                sel_vld[s] |-> sel_vld[s-1]);
            assert_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
                sel_vld[s] |-> ({1'b0, sel_ofs[s]} ==
                               POS_W'(sel_ofs[s-1]) + POS_W'(sel_len[s-1])));
        end
    endgenerate

endmodule

// File: rtl/vlb_boundary_finder.sv
module vlb_boundary_finder
    import vlb_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int SLOTS     = 4,
    parameter int MAX_PFX   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WIN_BYTES*8-1:0]      win_bytes,
    input  logic [WIN_BYTES-1:0]        win_valid,
    input  logic                        dn_ready,
    output logic [SLOTS-1:0]            slot_vld,
    output logic [SLOTS*4-1:0]          slot_ofs,
    output logic [SLOTS*4-1:0]          slot_len,
    output logic [4:0]                  adv_bytes,
    output logic                        need_bytes
);
    localparam int POS_W = $clog2(WIN_BYTES + 1);
    localparam int OFS_W = $clog2(WIN_BYTES);
    localparam int LEN_W = $clog2(MAX_PFX + 9);

    logic [POS_W-1:0]                nvalid;
    logic                            run;
    logic [WIN_BYTES-1:0][LEN_W-1:0] lane_len;
    logic [WIN_BYTES-1:0]            lane_unh;
    logic [WIN_BYTES-1:0]            lane_inc;
    logic [SLOTS-1:0][OFS_W-1:0]     sel_ofs;
    logic [SLOTS-1:0][LEN_W-1:0]     sel_len;
    logic [POS_W-1:0]                sel_end;
    stop_e                           stop_now;
    logic [5:0]                      issued_sum;

    // Valid count: leading run of ones only.
    always_comb begin
        nvalid = '0;
        run    = 1'b1;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (run && win_valid[i]) nvalid = nvalid + 1'b1;
            else                     run    = 1'b0;
        end
    end

    generate
        for (genvar k = 0; k < WIN_BYTES; k++) begin : g_lane
            localparam int SPAN = (k == 0) ? (MAX_PFX + 1) : 1;
            vlb_lane_len #(
                .WIN_BYTES (WIN_BYTES),
                .LANE      (k),
                .MAX_PFX   (MAX_PFX),
                .LEN_W     (LEN_W),
                .POS_W     (POS_W),
                .SPAN      (SPAN)
            ) lane_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .lane_bytes (win_bytes[k*8 +: SPAN*8]),
                .nvalid     (nvalid),
                .len        (lane_len[k]),
                .unhandled  (lane_unh[k]),
                .incomplete (lane_inc[k])
            );
        end
    endgenerate

    vlb_chain_select #(
        .WIN_BYTES (WIN_BYTES),
        .SLOTS     (SLOTS),
        .LEN_W     (LEN_W),
        .POS_W     (POS_W),
        .OFS_W     (OFS_W)
    ) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_len (lane_len),
        .lane_unh (lane_unh),
        .lane_inc (lane_inc),
        .sel_vld  (slot_vld),
        .sel_ofs  (sel_ofs),
        .sel_len  (sel_len),
        .sel_end  (sel_end),
        .stop_now (stop_now)
    );

    // Output process driven by the walk's stop state.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            slot_ofs[s*4 +: 4] = 4'(sel_ofs[s]);
            slot_len[s*4 +: 4] = 4'(sel_len[s]);
        end
        unique case (stop_now)
            STOP_STARVE: begin
                need_bytes = 1'b1;
                adv_bytes  = '0;
            end
            STOP_DEFER: begin
                need_bytes = 1'b0;
                adv_bytes  = dn_ready ? 5'(sel_end) : 5'd0;
            end
            STOP_EDGE: begin
                need_bytes = 1'b0;
                adv_bytes  = dn_ready ? 5'(sel_end) : 5'd0;
            end
            STOP_FULL: begin
                need_bytes = 1'b0;
                adv_bytes  = dn_ready ? 5'(sel_end) : 5'd0;
            end
        endcase
    end

    always_comb begin
        issued_sum = '0;
        for (int s = 0; s < SLOTS; s++)
            if (slot_vld[s]) issued_sum = issued_sum + 6'(slot_len[s*4 +: 4]);
    end

    assert_starve_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        need_bytes |-> (slot_vld == '0) && (adv_bytes == 5'd0));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_ready |-> adv_bytes == 5'd0);
    assert_adv_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_ready |-> {1'b0, adv_bytes} == issued_sum);
    assert_slot0_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[0] |-> slot_ofs[3:0] == 4'd0);
    assert_fit_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issued_sum <= 6'(nvalid)));

endmodule

// File: tb/vlb_boundary_finder_tb.sv
module vlb_boundary_finder_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int STREAM_LEN  = 8192;
    localparam int RAND_CYCLES = 3000;
    localparam int WATCHDOG    = 50000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] win_bytes = '0;
    logic [15:0]  win_valid = '0;
    logic         dn_ready = 1'b0;
    logic [3:0]   slot_vld;
    logic [15:0]  slot_ofs;
    logic [15:0]  slot_len;
    logic [4:0]   adv_bytes;
    logic         need_bytes;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlb_boundary_finder dut_i (
        .clk(clk), .rst_n(rst_n), .win_bytes(win_bytes), .win_valid(win_valid),
        .dn_ready(dn_ready), .slot_vld(slot_vld), .slot_ofs(slot_ofs),
        .slot_len(slot_len), .adv_bytes(adv_bytes), .need_bytes(need_bytes)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    int wb[16];
    int nval_m;
    int e_cnt, e_adv;
    int e_ofs[4];
    int e_len[4];
    bit e_need, e_defer, e_defer_fits;
    int stream[STREAM_LEN];
    int b[16];

    function automatic bit pfx(int v);
        return (v >= 8'hF0) && (v <= 8'hF7);
    endfunction

    function automatic int blen(int v);
        case (v / 64)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int full_len(int off);
        int p = 0;
        while (p < 3 && off + p < 16 && pfx(wb[off+p])) p++;
        if (off + p >= 16) return 99;
        return p + blen(wb[off+p]);
    endfunction

    task automatic ref_walk();
        int pos = 0;
        int l;
        e_cnt = 0; e_need = 0; e_defer = 0; e_defer_fits = 0;
        while (e_cnt < 4 && pos < 16) begin
            if (pos == 0) begin
                l = full_len(0);
                if (l > nval_m) begin e_need = 1; break; end
            end else begin
                if (pfx(wb[pos])) begin
                    e_defer = 1;
                    e_defer_fits = (full_len(pos) <= nval_m - pos);
                    break;
                end
                l = blen(wb[pos]);
                if (pos + l > 16) begin e_defer = 1; break; end
                if (pos + l > nval_m) break;
            end
            e_ofs[e_cnt] = pos;
            e_len[e_cnt] = l;
            e_cnt++;
            pos += l;
        end
        e_adv = pos;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] m, input logic r);
        for (int j = 0; j < 16; j++) begin
            wb[j] = b[j];
            win_bytes[j*8 +: 8] = 8'(b[j]);
        end
        win_valid = m;
        dn_ready  = r;
        nval_m = 0;
        while (nval_m < 16 && m[nval_m]) nval_m++;
        #1;
        ref_walk();
    endtask

    task automatic check_model();
        int ev = (1 << e_cnt) - 1;
        bit ok = (int'(slot_vld) == ev);
        for (int s = 0; s < 4; s++)
            if (s < e_cnt && (int'(slot_ofs[s*4 +: 4]) != e_ofs[s] ||
                              int'(slot_len[s*4 +: 4]) != e_len[s])) ok = 0;
        chk(ok, "R3", "slot set", int'(slot_vld), ev);
        chk(int'(adv_bytes) == (dn_ready ? e_adv : 0), "R8", "advance",
            int'(adv_bytes), dn_ready ? e_adv : 0);
        chk(need_bytes == e_need, "R7", "need_bytes", int'(need_bytes), int'(e_need));
    endtask

    task automatic exp_slot(int s, int ofs, int len, string req);
        chk(slot_vld[s] && int'(slot_ofs[s*4 +: 4]) == ofs && int'(slot_len[s*4 +: 4]) == len,
            req, $sformatf("slot%0d ofs*16+len", s),
            int'(slot_ofs[s*4 +: 4]) * 16 + int'(slot_len[s*4 +: 4]), ofs * 16 + len);
    endtask

    task automatic fill(int v);
        for (int j = 0; j < 16; j++) b[j] = v;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            finish_run();
        end
    end

    initial begin
        int pc = 0;
        int avail = 0;
        bit prev_fits = 0;
        logic [15:0] m;
        logic r;
        int first_gap;

        // Reset state with an empty window
        fill(0);
        repeat (3) @(negedge clk);
        drive(16'h0000, 1'b1);
        chk(need_bytes == 1'b1 && slot_vld == 4'd0 && adv_bytes == 5'd0, "R7",
            "empty window", int'(slot_vld), 0);
        rst_n = 1'b1;

        // R1: each base length in a chain
        @(negedge clk);
        fill(0); b[1] = 8'h41; b[3] = 8'h80; b[7] = 8'hC0;
        drive(16'hFFFF, 1'b1);
        exp_slot(0, 0, 1, "R1"); exp_slot(1, 1, 2, "R1");
        exp_slot(2, 3, 4, "R1"); exp_slot(3, 7, 8, "R1");
        chk(adv_bytes == 5'd15, "R8", "R1 window advance", int'(adv_bytes), 15);
        check_model();

        // R8: ready low keeps slots, zero advance
        @(negedge clk);
        drive(16'hFFFF, 1'b0);
        chk(slot_vld == 4'hF && adv_bytes == 5'd0, "R8", "ready low",
            int'(adv_bytes), 0);
        check_model();

        // R2: three prefixes
        @(negedge clk);
        fill(0); b[0] = 8'hF0; b[1] = 8'hF1; b[2] = 8'hF2; b[3] = 8'h05;
        drive(16'hFFFF, 1'b1);
        exp_slot(0, 0, 4, "R2"); exp_slot(1, 4, 1, "R2");
        chk(adv_bytes == 5'd7, "R2", "advance after prefixes", int'(adv_bytes), 7);
        check_model();

        // R2: fourth prefix-range byte is the opcode
        @(negedge clk);
        fill(0); b[0] = 8'hF0; b[1] = 8'hF0; b[2] = 8'hF0; b[3] = 8'hF0;
        drive(16'hFFFF, 1'b1);
        exp_slot(0, 0, 11, "R2"); exp_slot(1, 11, 1, "R2");
        check_model();

        // R4: prefix at offset 1 defers
        @(negedge clk);
        fill(0); b[1] = 8'hF3; b[2] = 8'h45;
        drive(16'hFFFF, 1'b1);
        chk(slot_vld == 4'b0001 && adv_bytes == 5'd1, "R4", "defer at prefix",
            int'(adv_bytes), 1);
        check_model();

        // R9: shifted window issues it at offset 0
        @(negedge clk);
        fill(0); b[0] = 8'hF3; b[1] = 8'h45;
        drive(16'hFFFF, 1'b1);
        exp_slot(0, 0, 3, "R9");
        check_model();

        // R5: overlong at offset 12
        @(negedge clk);
        fill(0); b[0] = 8'h80; b[4] = 8'hC0; b[12] = 8'hC0;
        drive(16'hFFFF, 1'b1);
        chk(slot_vld == 4'b0011 && adv_bytes == 5'd12, "R5", "overlong lane",
            int'(adv_bytes), 12);
        check_model();

        // R6: ones above the first zero ignored
        @(negedge clk);
        fill(8'h40);
        drive(16'hF007, 1'b1);
        chk(slot_vld == 4'b0001 && adv_bytes == 5'd2, "R6", "mask gap",
            int'(adv_bytes), 2);
        check_model();

        // R7: byte 0 incomplete
        @(negedge clk);
        fill(0); b[0] = 8'hC0;
        drive(16'h007F, 1'b1);
        chk(need_bytes && slot_vld == 4'd0 && adv_bytes == 5'd0, "R7",
            "starve", int'(need_bytes), 1);
        check_model();

        // R3: walk ends at byte 16
        @(negedge clk);
        fill(0); b[0] = 8'hC0; b[8] = 8'hC0;
        drive(16'hFFFF, 1'b1);
        chk(slot_vld == 4'b0011 && adv_bytes == 5'd16, "R3", "window end",
            int'(adv_bytes), 16);
        check_model();

        // Random stream against the behavioural reference
        for (int i = 0; i < STREAM_LEN; i++)
            stream[i] = ($urandom_range(0, 99) < 15) ? (8'hF0 + $urandom_range(0, 7))
                                                     : $urandom_range(0, 239);
        for (int c = 0; c < RAND_CYCLES; c++) begin
            @(negedge clk);
            avail += $urandom_range(0, 10);
            if (avail > STREAM_LEN) avail = STREAM_LEN;
            first_gap = 16;
            for (int j = 0; j < 16; j++) begin
                if (pc + j < avail) begin
                    b[j] = stream[pc+j];
                    m[j] = 1'b1;
                end else begin
                    b[j] = $urandom_range(0, 255);
                    if (first_gap == 16) first_gap = j;
                    m[j] = (j == first_gap) ? 1'b0 : 1'($urandom_range(0, 1));
                end
            end
            r = ($urandom_range(0, 3) != 0);
            drive(m, r);
            check_model();
            if (prev_fits)
                chk(slot_vld[0] == 1'b1, "R9", "deferred issue", int'(slot_vld[0]), 1);
            if (r) begin
                pc += e_adv;
                prev_fits = e_defer && e_defer_fits;
            end
        end

        done = 1;
        finish_run();
    end

endmodule